// File: doc/BRIEF.md
# Load/Store Ordering Matrix

This block keeps the ordering constraints between memory operations that are in flight at the same time in an out-of-order core. Each of a small number of load/store units owns one row and one column of a square matrix of dependency bits. When a unit issues, the block sets a bit in that unit's row for every older outstanding unit it must wait for. A unit may start its memory access once its row is empty. The block then raises that unit's ready output.

Bits are removed in two ways. The first is early: once both operations have supplied an address and the page-offset bits differ, the two accesses cannot overlap, so the bit is dropped. Only bits [11:0] are compared, because they are the same before and after address translation. The second is late: when the older operation reports completion, every bit pointing at it is cleared. Operations tagged as I/O or non-cacheable are never relaxed by the address check. They keep strict program order against every other operation.

Top module: `mem_dep_matrix`

## Requirements
- R1: After reset no unit is busy and every ready output is low.
- R2: An issued unit becomes busy on the issuing clock edge. Its ready bit is high from then on exactly while it is busy and its dependency row is empty. A store issued behind other stores only is ready at once.
- R3: A load issued while an older store is busy depends on that store. A store issued while an older load is busy depends on that load.
- R4: Two ordinary (non-I/O) loads never depend on each other. Two ordinary stores never depend on each other.
- R5: A completion for unit u, accepted at a clock edge, frees u and clears every dependency on u at that same edge. Units that were waiting only on u are ready right after that edge.
- R6: Addresses are compared on bits [11:0] only. For two units that both hold an accepted address, neither of them I/O, a dependency between them is dropped at the clock edge after the later address was accepted, if those bits differ. If bits [11:0] are equal, the dependency is kept, even when the upper bits differ.
- R7: An operation issued with the I/O flag depends on every older busy unit, loads included. Every later operation depends on an older busy I/O operation. Such dependencies are never dropped by the address check, only by completion.
- R8: When one unit issues in the same cycle that another unit completes, the issuing unit records no dependency on the completing one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Issue a new operation this cycle |
| iss_id | input | ID_W | Unit that receives the new operation |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_io | input | 1 | Operation targets I/O or non-cacheable space |
| adr_vld | input | 1 | An address for a busy unit is supplied |
| adr_id | input | ID_W | Unit the address belongs to |
| adr_val | input | ADDR_W | Untranslated address; only bits [OFS_W-1:0] are kept |
| done_vld | input | 1 | A unit reports its access as performed |
| done_id | input | ID_W | Unit that completes |
| ready | output | NUM_UNITS | Per unit: busy with no outstanding dependency |

## Verification
A store followed by a load is run twice. In the first run both addresses share the page offset and differ only above bit 11, so the address check must keep the load held. In the second run the offsets differ, so the load must be freed one edge after the second address. A run of loads followed by stores separates load-load and store-store independence from the load-to-store ordering. An I/O load surrounded by ordinary loads, with differing addresses, shows that strict order holds where ordinary traffic would be relaxed. A completion that coincides with an issue checks that the new unit ignores the departing one.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    // untranslated page-offset width used for the clash check
    localparam int unsigned PAGE_OFS_W = 12;

    // two operations must stay ordered when either is I/O, or when one
    // is a load and the other a store
    function automatic logic must_order(input logic st_a, input logic io_a,
                                        input logic st_b, input logic io_b);
        return io_a | io_b | (st_a ^ st_b);
    endfunction

endpackage

// File: rtl/mdm_offset_cmp.sv
// Pairwise page-offset comparator: flags pairs whose accesses cannot overlap.
module mdm_offset_cmp #(
    parameter int unsigned N     = 4,
    parameter int unsigned OFS_W = 12
) (
    input  logic [N-1:0]            avld,
    input  logic [N-1:0]            is_io,
    input  logic [N-1:0][OFS_W-1:0] ofs,
    output logic [N-1:0][N-1:0]     drop
);
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign drop[i][j] = avld[i] & avld[j] & ~is_io[i] & ~is_io[j]
                              & (ofs[i] != ofs[j]);
        end
    end
endmodule

// File: rtl/mdm_issue_mask.sv
// Row of dependency bits for a newly issued operation.
module mdm_issue_mask
    import mdm_pkg::*;
#(
    parameter int unsigned N    = 4,
    localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    busy,
    input  logic [N-1:0]    is_st,
    input  logic [N-1:0]    is_io,
    input  logic [ID_W-1:0] new_id,
    input  logic            new_st,
    input  logic            new_io,
    input  logic            retire_vld,
    input  logic [ID_W-1:0] retire_id,
    output logic [N-1:0]    mask
);
    always_comb begin
        mask = '0;
        for (int j = 0; j < N; j++) begin
            if (busy[j] && (ID_W'(j) != new_id)
                && !(retire_vld && (retire_id == ID_W'(j)))
                && must_order(new_st, new_io, is_st[j], is_io[j])) begin
                mask[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mem_dep_matrix.sv
module mem_dep_matrix
    import mdm_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFS_W     = PAGE_OFS_W,
    localparam int unsigned ID_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_vld,
    input  logic [ID_W-1:0]      iss_id,
    input  logic                 iss_store,
    input  logic                 iss_io,
    input  logic                 adr_vld,
    input  logic [ID_W-1:0]      adr_id,
    input  logic [ADDR_W-1:0]    adr_val,
    input  logic                 done_vld,
    input  logic [ID_W-1:0]      done_id,
    output logic [NUM_UNITS-1:0] ready
);
    localparam int unsigned N = NUM_UNITS;

    typedef struct packed {
        logic [N-1:0]            busy;
        logic [N-1:0]            is_st;
        logic [N-1:0]            is_io;
        logic [N-1:0]            avld;
        logic [N-1:0][OFS_W-1:0] ofs;
        logic [N-1:0][N-1:0]     dep;   // dep[i][j]: unit i waits on unit j
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0][N-1:0] drop;
    logic [N-1:0]        new_row;

    mdm_offset_cmp #(.N(N), .OFS_W(OFS_W)) u_cmp (
        .avld (st_q.avld),
        .is_io(st_q.is_io),
        .ofs  (st_q.ofs),
        .drop (drop)
    );

    mdm_issue_mask #(.N(N)) u_mask (
        .busy      (st_q.busy),
        .is_st     (st_q.is_st),
        .is_io     (st_q.is_io),
        .new_id    (iss_id),
        .new_st    (iss_store),
        .new_io    (iss_io),
        .retire_vld(done_vld),
        .retire_id (done_id),
        .mask      (new_row)
    );

    always_comb begin
        st_d = st_q;

        // early relaxation from the offset check
        for (int i = 0; i < N; i++) begin
            st_d.dep[i] = st_q.dep[i] & ~drop[i];
        end

        // completion frees row and column
        if (done_vld) begin
            st_d.busy[done_id] = 1'b0;
            st_d.avld[done_id] = 1'b0;
            st_d.dep[done_id]  = '0;
            for (int i = 0; i < N; i++) begin
                st_d.dep[i][done_id] = 1'b0;
            end
        end

        // address capture for a busy unit
        if (adr_vld && st_q.busy[adr_id]) begin
            st_d.avld[adr_id] = 1'b1;
            st_d.ofs[adr_id]  = adr_val[OFS_W-1:0];
        end

        // issue: new row, empty column, address not yet known
        if (iss_vld) begin
            st_d.busy[iss_id]  = 1'b1;
            st_d.is_st[iss_id] = iss_store;
            st_d.is_io[iss_id] = iss_io;
            st_d.avld[iss_id]  = 1'b0;
            st_d.dep[iss_id]   = new_row;
            for (int i = 0; i < N; i++) begin
                st_d.dep[i][iss_id] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ready[i] = st_q.busy[i] & ~(|st_q.dep[i]);
        end
    end

endmodule

// File: rtl/mdm_checker.sv
module mdm_checker #(
    parameter int unsigned N    = 4,
    localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                iss_vld,
    input logic [ID_W-1:0]     iss_id,
    input logic                done_vld,
    input logic [ID_W-1:0]     done_id,
    input logic [N-1:0]        ready,
    input logic [N-1:0]        busy,
    input logic [N-1:0]        is_st,
    input logic [N-1:0]        is_io,
    input logic [N-1:0][N-1:0] dep
);
    assert_ready_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready & ~busy) == '0);

    assert_issue_takes_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> busy[$past(iss_id)]);

    assert_no_dep_on_leaver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && done_vld && iss_id != done_id) |=> !dep[$past(iss_id)][$past(done_id)]);

    for (genvar i = 0; i < N; i++) begin : g_i
        assert_no_self_dep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !dep[i][i]);
        for (genvar j = 0; j < N; j++) begin : g_j
            assert_same_kind_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
                dep[i][j] |-> ((is_st[i] ^ is_st[j]) | is_io[i] | is_io[j]));
            assert_dep_between_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
                dep[i][j] |-> (busy[i] && busy[j]));
            assert_done_clears_column_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (done_vld && done_id == ID_W'(j)) |=> !dep[i][j]);
        end
    end
endmodule

bind mem_dep_matrix mdm_checker #(.N(NUM_UNITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_vld (iss_vld),
    .iss_id  (iss_id),
    .done_vld(done_vld),
    .done_id (done_id),
    .ready   (ready),
    .busy    (st_q.busy),
    .is_st   (st_q.is_st),
    .is_io   (st_q.is_io),
    .dep     (st_q.dep)
);

// File: tb/test_mem_dep_matrix.sv
`timescale 1ns/1ps
module test_mem_dep_matrix;
    localparam int NU = 4;
    localparam int IW = 2;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_vld = 0, iss_store = 0, iss_io = 0, adr_vld = 0, done_vld = 0;
    logic [IW-1:0] iss_id = '0, adr_id = '0, done_id = '0;
    logic [AW-1:0] adr_val = '0;
    logic [NU-1:0] ready;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mem_dep_matrix #(.NUM_UNITS(NU), .ADDR_W(AW), .OFS_W(12)) i_mem_dep_matrix (
        .clk(clk), .rst_n(rst_n),
        .iss_vld(iss_vld), .iss_id(iss_id), .iss_store(iss_store), .iss_io(iss_io),
        .adr_vld(adr_vld), .adr_id(adr_id), .adr_val(adr_val),
        .done_vld(done_vld), .done_id(done_id),
        .ready(ready)
    );

    // behavioural reference: per-unit records and a waits-on list
    bit m_busy[NU], m_st[NU], m_io[NU], m_has[NU];
    int m_off[NU];
    bit m_wait[NU][NU];

    function automatic logic [NU-1:0] model_ready();
        logic [NU-1:0] r = '0;
        for (int u = 0; u < NU; u++) begin
            int waits = 0;
            for (int v = 0; v < NU; v++) waits += m_wait[u][v];
            r[u] = m_busy[u] && waits == 0;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        bit o_busy[NU], o_st[NU], o_io[NU], o_has[NU];
        int o_off[NU];
        bit o_wait[NU][NU];
        o_busy = m_busy; o_st = m_st; o_io = m_io; o_has = m_has;
        o_off = m_off; o_wait = m_wait;
        if (!rst_n) begin
            for (int u = 0; u < NU; u++) begin
                m_busy[u] = 0; m_st[u] = 0; m_io[u] = 0; m_has[u] = 0; m_off[u] = 0;
                for (int v = 0; v < NU; v++) m_wait[u][v] = 0;
            end
        end else begin
            for (int u = 0; u < NU; u++)
                for (int v = 0; v < NU; v++)
                    if (o_has[u] && o_has[v] && !o_io[u] && !o_io[v] && o_off[u] != o_off[v])
                        m_wait[u][v] = 0;
            if (done_vld) begin
                m_busy[done_id] = 0; m_has[done_id] = 0;
                for (int v = 0; v < NU; v++) begin
                    m_wait[v][done_id] = 0; m_wait[done_id][v] = 0;
                end
            end
            if (adr_vld && o_busy[adr_id]) begin
                m_has[adr_id] = 1; m_off[adr_id] = int'(adr_val % 4096);
            end
            if (iss_vld) begin
                m_busy[iss_id] = 1; m_st[iss_id] = iss_store; m_io[iss_id] = iss_io;
                m_has[iss_id] = 0;
                for (int v = 0; v < NU; v++) begin
                    m_wait[v][iss_id] = 0;
                    m_wait[iss_id][v] = o_busy[v] && v != int'(iss_id)
                        && !(done_vld && int'(done_id) == v)
                        && (iss_io || o_io[v] || iss_store != o_st[v]);
                end
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (ready !== model_ready()) begin
                errors++;
                $display("FAIL R2 model compare: ready=%b expected=%b at %0t", ready, model_ready(), $time);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_ready(input logic [NU-1:0] exp, input string tag);
        checks++;
        if (ready !== exp) begin
            errors++;
            $display("FAIL %s: ready=%b expected=%b", tag, ready, exp);
        end
    endtask

    task automatic issue(input int u, input bit st, input bit io);
        iss_vld = 1; iss_id = IW'(u); iss_store = st; iss_io = io;
        tick();
        iss_vld = 0; iss_io = 0;
    endtask

    task automatic give_addr(input int u, input logic [AW-1:0] a);
        adr_vld = 1; adr_id = IW'(u); adr_val = a;
        tick();
        adr_vld = 0;
    endtask

    task automatic finish_unit(input int u);
        done_vld = 1; done_id = IW'(u);
        tick();
        done_vld = 0;
    endtask

    initial begin
        repeat (3) tick();
        expect_ready(4'b0000, "R1 reset");
        rst_n = 1;
        tick();
        expect_ready(4'b0000, "R1 after reset");

        // same offset, different upper bits: load stays held
        issue(0, 1, 0);
        expect_ready(4'b0001, "R2 lone store");
        issue(1, 0, 0);
        expect_ready(4'b0001, "R3 load behind store");
        give_addr(0, 32'h0000_1234);
        give_addr(1, 32'h0000_5234);
        tick();
        expect_ready(4'b0001, "R6 equal offset keeps load");
        finish_unit(0);
        expect_ready(4'b0010, "R5 completion releases load");
        finish_unit(1);
        expect_ready(4'b0000, "R5 all free");

        // different offsets: load released by the address check
        issue(0, 1, 0);
        issue(1, 0, 0);
        give_addr(0, 32'h0000_0100);
        give_addr(1, 32'h0000_0200);
        expect_ready(4'b0001, "R6 not yet compared");
        tick();
        expect_ready(4'b0011, "R6 differing offsets release");
        finish_unit(0);
        finish_unit(1);

        // loads then stores
        issue(0, 0, 0);
        issue(1, 0, 0);
        expect_ready(4'b0011, "R4 two loads independent");
        issue(2, 1, 0);
        expect_ready(4'b0011, "R3 store behind loads");
        issue(3, 1, 0);
        expect_ready(4'b0011, "R4 store after store only waits on loads");
        finish_unit(0);
        expect_ready(4'b0010, "R5 partial release");
        finish_unit(1);
        expect_ready(4'b1100, "R4 stores ready together");
        finish_unit(2);
        finish_unit(3);

        // I/O load in strict order
        issue(0, 0, 0);
        issue(1, 0, 1);
        expect_ready(4'b0001, "R7 io load waits on load");
        give_addr(0, 32'h10);
        give_addr(1, 32'h20);
        tick();
        expect_ready(4'b0001, "R7 address check ignored for io");
        issue(2, 0, 0);
        expect_ready(4'b0001, "R7 load behind io");
        finish_unit(0);
        expect_ready(4'b0010, "R7 io proceeds");
        finish_unit(1);
        expect_ready(4'b0100, "R7 later load proceeds");
        finish_unit(2);

        // issue while another unit completes
        issue(0, 1, 0);
        issue(1, 0, 0);
        iss_vld = 1; iss_id = 2'd2; iss_store = 0; iss_io = 0;
        done_vld = 1; done_id = 2'd0;
        tick();
        iss_vld = 0; done_vld = 0;
        expect_ready(4'b0110, "R8 no dependency on completing unit");
        finish_unit(1);
        finish_unit(2);
        expect_ready(4'b0000, "R5 drained");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: ready=%b expected=completion", ready);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule